// File: doc/BRIEF.md
# Background Loop Gain Servo

This block tunes the proportional gain of a bang-bang phase-locked loop while the loop is running. Once per reference period it takes the sign bit from the centre comparator, treats it as +1 or −1, and multiplies it by the sign bit from the period before. The product is the sign-sign lag-one autocorrelation of the decision stream. When neighbouring decisions agree, the loop is reacting too slowly and the gain is raised. When they disagree, the loop is overreacting and the gain is lowered. At the optimum, agreements and disagreements balance, so the average correlation is zero and the gain settles around a fixed value.

The products are summed in an internal register that has `FRAC_W` bits more than the gain word, so one correlation sample moves the gain by only a fraction of an LSB. The upper `GAIN_W` bits of that register drive the loop filter. The sum clamps at programmable limits instead of wrapping. While the enable is low the gain holds its value, but the incoming decision is still stored as the previous one. The default configuration uses a 13-bit gain word, and the fractional width is chosen so that the worst-case settling from the initial gain fits in the allowed time budget of 750 µs.

Top module: `loop_gain_servo`

## Requirements
- R1: While `rst_n` is low, `gain_o` equals `GAIN_INIT` (the internal sum is `GAIN_INIT·2^FRAC_W`), and no previous decision is held.
- R2: `dec_i` = 1 means +1 and `dec_i` = 0 means −1. The decision is taken only on clock edges where `ref_stb_i` is high. On every other cycle `gain_o` holds, whatever `dec_i` and `en_i` do.
- R3: On an enabled strobe, if the current decision equals the previous one (product +1), the internal sum rises by one. If they differ (product −1), the sum falls by one.
- R4: `gain_o` is the internal sum shifted right by `FRAC_W`, so one step is 2^−FRAC_W of a gain LSB. `gain_o` changes by at most one per strobe.
- R5: The first strobe after reset only stores its decision and leaves the sum unchanged.
- R6: A strobe with `en_i` low leaves the sum unchanged, but still stores its decision as the previous one for the next strobe.
- R7: The sum never exceeds `GAIN_MAX·2^FRAC_W + 2^FRAC_W − 1`. Further agreeing products keep it there, and `gain_o` stays at `GAIN_MAX`.
- R8: The sum never falls below `GAIN_MIN·2^FRAC_W`. Further opposing products keep it there, and `gain_o` stays at `GAIN_MIN`.
- R9: A change caused by a strobe appears on `gain_o` in the clock cycle after the edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_stb_i | input | 1 | One-cycle pulse, one per reference period |
| dec_i | input | 1 | Centre comparator sign: 1 is +1, 0 is −1 |
| en_i | input | 1 | Adaptation enable |
| gain_o | output | GAIN_W | Proportional gain word to the loop filter |

## Verification
Every result here is due exactly one clock after the edge that samples the strobe. That edge updates the registered sum, and `gain_o` is a plain slice of that sum. The bench drives a strobe on a falling edge, lowers it on the next falling edge, and compares `gain_o` at that same falling edge, which is the point where the single register has updated and nothing else can move. The no-effect cases (no strobe, enable low) are compared at the same point. For the enable-low case, the stored decision is also brought out by the product of the next enabled strobe.

// File: rtl/lgo_pkg.sv
package lgo_pkg;

  // Outcome of one lag-one sign product
  typedef enum logic [1:0] {
    CORR_NONE   = 2'b00,
    CORR_AGREE  = 2'b01,
    CORR_OPPOSE = 2'b10
  } corr_e;

  // Sign-sign product of two decisions (1 = +1, 0 = -1)
  function automatic corr_e sign_product(input logic cur, input logic prev);
    return (cur == prev) ? CORR_AGREE : CORR_OPPOSE;
  endfunction

endpackage

// File: rtl/lgo_lag_tap.sv
module lgo_lag_tap
  import lgo_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stb_i,
  input  logic  dec_i,
  input  logic  en_i,
  output corr_e corr_o
);

  logic prev_q;
  logic have_prev_q;

  // The delay element follows every strobe, enabled or not
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= 1'b0;
      have_prev_q <= 1'b0;
    end else if (stb_i) begin
      prev_q      <= dec_i;
      have_prev_q <= 1'b1;
    end
  end

  always_comb begin
    if (stb_i && en_i && have_prev_q) corr_o = sign_product(dec_i, prev_q);
    else                              corr_o = CORR_NONE;
  end

endmodule

// File: rtl/lgo_gain_accum.sv
module lgo_gain_accum #(
  parameter int unsigned GAIN_W    = 13,
  parameter int unsigned FRAC_W    = 4,
  parameter int unsigned GAIN_INIT = 512,
  parameter int unsigned GAIN_MIN  = 1,
  parameter int unsigned GAIN_MAX  = 8191
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_i,
  input  logic              dn_i,
  output logic [GAIN_W-1:0] gain_o
);

  localparam int unsigned ACC_W = GAIN_W + FRAC_W;
  localparam logic [ACC_W-1:0] FRAC_ONES = ACC_W'((64'd1 << FRAC_W) - 64'd1);
  localparam logic [ACC_W-1:0] ACC_INIT  = ACC_W'(GAIN_INIT) << FRAC_W;
  localparam logic [ACC_W-1:0] ACC_LO    = ACC_W'(GAIN_MIN) << FRAC_W;
  localparam logic [ACC_W-1:0] ACC_HI    = (ACC_W'(GAIN_MAX) << FRAC_W) | FRAC_ONES;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;

  // Saturating unit step of the correlation sum
  function automatic logic [ACC_W-1:0] sat_step(input logic [ACC_W-1:0] acc,
                                                input logic up, input logic dn);
    logic [ACC_W-1:0] r;
    r = acc;
    if (up)      r = (acc >= ACC_HI) ? ACC_HI : acc + ACC_W'(1);
    else if (dn) r = (acc <= ACC_LO) ? ACC_LO : acc - ACC_W'(1);
    return r;
  endfunction

  assign acc_d = sat_step(acc_q, up_i, dn_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= ACC_INIT;
    else        acc_q <= acc_d;
  end

  assign gain_o = acc_q[ACC_W-1 -: GAIN_W];

endmodule

// File: rtl/loop_gain_servo.sv
module loop_gain_servo
  import lgo_pkg::*;
#(
  parameter int unsigned GAIN_W    = 13,
  parameter int unsigned FRAC_W    = 4,
  parameter int unsigned GAIN_INIT = 512,
  parameter int unsigned GAIN_MIN  = 1,
  parameter int unsigned GAIN_MAX  = 8191
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_stb_i,
  input  logic              dec_i,
  input  logic              en_i,
  output logic [GAIN_W-1:0] gain_o
);

  corr_e corr;
  logic  step_up;
  logic  step_dn;

  lgo_lag_tap tap_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb_i  (ref_stb_i),
    .dec_i  (dec_i),
    .en_i   (en_i),
    .corr_o (corr)
  );

  // Named step events, also seen by the bound checker
  assign step_up = (corr == CORR_AGREE);
  assign step_dn = (corr == CORR_OPPOSE);

  lgo_gain_accum #(
    .GAIN_W    (GAIN_W),
    .FRAC_W    (FRAC_W),
    .GAIN_INIT (GAIN_INIT),
    .GAIN_MIN  (GAIN_MIN),
    .GAIN_MAX  (GAIN_MAX)
  ) acc_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .up_i   (step_up),
    .dn_i   (step_dn),
    .gain_o (gain_o)
  );

endmodule

// File: rtl/loop_gain_servo_chk.sv
module loop_gain_servo_chk #(
  parameter int unsigned GAIN_W   = 13,
  parameter int unsigned GAIN_MIN = 1,
  parameter int unsigned GAIN_MAX = 8191
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_stb_i,
  input logic              en_i,
  input logic              step_up,
  input logic              step_dn,
  input logic [GAIN_W-1:0] gain_o
);

  // R2
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_stb_i |=> $stable(gain_o));

  // R6
  disabled_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_stb_i && !en_i) |=> $stable(gain_o));

  // R4
  unit_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_stb_i |=> (gain_o == $past(gain_o) || gain_o == $past(gain_o) + 1'b1 ||
                   gain_o == $past(gain_o) - 1'b1));

  // R3
  rise_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |=> gain_o >= $past(gain_o));

  // R3
  fall_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |=> gain_o <= $past(gain_o));

  // R7
  upper_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gain_o <= GAIN_W'(GAIN_MAX));

  // R8
  lower_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gain_o >= GAIN_W'(GAIN_MIN));

endmodule

bind loop_gain_servo loop_gain_servo_chk #(
  .GAIN_W   (GAIN_W),
  .GAIN_MIN (GAIN_MIN),
  .GAIN_MAX (GAIN_MAX)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_stb_i (ref_stb_i),
  .en_i      (en_i),
  .step_up   (step_up),
  .step_dn   (step_dn),
  .gain_o    (gain_o)
);

// File: tb/loop_gain_servo_tb_top.sv
module loop_gain_servo_tb_top;

  localparam int GW   = 13;
  localparam int FW   = 1;
  localparam int GI   = 64;
  localparam int GMIN = 60;
  localparam int GMAX = 70;
  localparam int AMAX = GMAX * (1 << FW) + (1 << FW) - 1;
  localparam int AMIN = GMIN * (1 << FW);

  // {dec, en, step}: step 01 = +1, 11 = -1, 00 = none
  localparam logic [3:0] VEC [16] = '{
    4'b1100, 4'b1101, 4'b1101, 4'b0111,
    4'b1111, 4'b0111, 4'b0000, 4'b0101,
    4'b1000, 4'b1101, 4'b1101, 4'b0111,
    4'b0101, 4'b1111, 4'b1101, 4'b1101
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0;
  logic dec = 1'b0;
  logic en = 1'b0;
  wire [GW-1:0] gain;

  int checks = 0;
  int errors = 0;
  int exp_acc = GI << FW;
  logic prev_m = 1'b0;
  bit valid_m = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  loop_gain_servo #(
    .GAIN_W (GW), .FRAC_W (FW), .GAIN_INIT (GI), .GAIN_MIN (GMIN), .GAIN_MAX (GMAX)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .ref_stb_i (stb), .dec_i (dec), .en_i (en), .gain_o (gain)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clamp(input int v);
    if (v > AMAX) return AMAX;
    if (v < AMIN) return AMIN;
    return v;
  endfunction

  // Strobe at a falling edge, compare at the following falling edge (R9)
  task automatic pulse(input logic d, input logic e);
    @(negedge clk); stb = 1'b1; dec = d; en = e;
    @(negedge clk); stb = 1'b0;
  endtask

  task automatic model_pulse(input logic d, input logic e, input string req);
    pulse(d, e);
    if (valid_m && e) exp_acc = clamp(exp_acc + ((d == prev_m) ? 1 : -1));
    prev_m = d; valid_m = 1'b1;
    chk(req, int'(gain), exp_acc >> FW);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset value
    repeat (3) @(negedge clk);
    chk("R1 reset gain", int'(gain), GI);
    rst_n = 1'b1;

    // Table walk: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < 16; i++) begin
      logic [1:0] st;
      int delta;
      st = VEC[i][1:0];
      delta = (st == 2'b01) ? 1 : ((st == 2'b11) ? -1 : 0);
      pulse(VEC[i][3], VEC[i][2]);
      exp_acc = clamp(exp_acc + delta);
      prev_m = VEC[i][3]; valid_m = 1'b1;
      chk($sformatf("R3 R5 R6 vector %0d", i), int'(gain), exp_acc >> FW);
    end

    // R2: decision toggles with no strobe, gain holds
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); dec = ~dec; en = 1'b1;
    end
    @(negedge clk);
    chk("R2 no strobe hold", int'(gain), exp_acc >> FW);

    // R7: long same-sign run saturates at the top
    for (int i = 0; i < 20; i++) model_pulse(1'b1, 1'b1, "R7 upper clamp");
    chk("R7 gain at max", int'(gain), GMAX);
    model_pulse(1'b1, 1'b1, "R7 stays at max");

    // R8: alternation saturates at the bottom
    for (int i = 0; i < 30; i++) model_pulse(logic'(i % 2 == 0 ? 0 : 1), 1'b1, "R8 lower clamp");
    chk("R8 gain at min", int'(gain), GMIN);
    model_pulse(~prev_m, 1'b1, "R8 stays at min");

    // R6: disabled strobe stores decision; next enabled product uses it
    model_pulse(1'b1, 1'b0, "R6 frozen");
    model_pulse(1'b1, 1'b1, "R6 stored decision agree");
    model_pulse(1'b1, 1'b1, "R4 step");
    model_pulse(1'b1, 1'b1, "R4 step");

    // R1 R5: reset mid-run, first strobe after only stores
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset", int'(gain), GI);
    rst_n = 1'b1;
    exp_acc = GI << FW; valid_m = 1'b0;
    model_pulse(1'b0, 1'b1, "R5 first strobe no update");
    model_pulse(1'b0, 1'b1, "R3 agree after reset");
    model_pulse(1'b0, 1'b1, "R3 agree after reset");
    chk("R4 two half steps", int'(gain), GI + 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule